// File: doc/BRIEF.md
# Arithmetic Unit with Processor Status Flags

This block pairs an 8-bit arithmetic datapath with the processor status word that records how the last operation turned out. Two operands and a 3-bit operation code select one of six operations: add, add with carry-in, subtract, increment, decrement or logical shift left. The result leaves the block combinationally in the same cycle. When the operation strobe is high, the six condition flags are latched on the next rising clock edge: carry, zero, negative, two's-complement overflow, sign and half-carry.

Two further bits in the word are not touched by arithmetic. One is a general-purpose user bit. The other is a global interrupt-enable bit, which is only stored and driven out. A single-bit command port sets or clears any one of the eight bits. A full-word write port loads the whole register and wins over every other update in the same cycle.

An instruction decoder drives the block. The decoder owns the register file and any branching logic, and it reads the status word back from the `status` output.

Top module: `alu_status_unit`

## Requirements
- R1: The status word has this bit layout: bit 7 interrupt enable (I), bit 6 user bit (T), bit 5 half-carry (H), bit 4 sign (S), bit 3 overflow (V), bit 2 negative (N), bit 1 zero (Z), bit 0 carry (C). A synchronous active-low reset clears all eight bits to 0x00 on a clock edge.
- R2: `op_code` selects the `result` combinationally: 0 gives a+b, 1 gives a+b+C, 2 gives a-b, 3 gives a+1, 4 gives a-1 and 5 gives a shifted left by one with a zero entering bit 0. Codes 6 and 7 give a result of 0x00.
- R3: After add or add-with-carry, C is the carry out of bit 7. After subtract, C is set when b is greater than a as unsigned numbers. After shift-left, C is the old bit 7 of a. Increment and decrement leave C unchanged.
- R4: After any valid operation, Z is set exactly when the 8-bit result is 0x00, and N equals bit 7 of the result.
- R5: V flags signed overflow. For add, it is set when the operands share a sign and the result differs from it. For subtract, it is set when the operands differ in sign and the result differs from a. For increment, it is set only when a is 0x7F. For decrement, it is set only when a is 0x80. For shift-left, V is the XOR of the old bits 7 and 6 of a.
- R6: After any valid operation, S equals N XOR V.
- R7: H marks a carry out of bit 3 for add, add-with-carry and increment, and a borrow into bit 3 for subtract and decrement. For shift-left, H is the old bit 3 of a.
- R8: Operations never change T or I. Codes 6 and 7 change no bit of the status word.
- R9: With `flag_cmd_valid` high, bit number `flag_cmd_sel` (0 to 7, per the R1 layout) takes the value of `flag_cmd_set` on the next edge. No other bit changes because of the command. All sixteen set and clear combinations are available.
- R10: With `wr_en` high, the next edge loads `wr_data` into the whole status word. This takes priority over an operation and a flag command in the same cycle.
- R11: Flags change only on the edge that follows a cycle with `op_valid`, `flag_cmd_valid` or `wr_en` high. When an operation and a flag command arrive in the same cycle, the operation's flags are applied first and the command then decides its one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe; flags latch on the next edge |
| op_code | input | 3 | Operation select (R2 encoding) |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand (unused by increment, decrement and shift) |
| result | output | 8 | Combinational operation result |
| flag_cmd_valid | input | 1 | Single-bit flag command strobe |
| flag_cmd_set | input | 1 | 1 sets, 0 clears the selected bit |
| flag_cmd_sel | input | 3 | Bit index the command acts on |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 8 | Word loaded by a full write |
| status | output | 8 | Current status word |

## Verification
On every cycle, the assertions check four things. A full write always lands. T and I survive an operation. S equals N XOR V after an operation, and Z and N track the result. A lone flag command flips at most its own bit, and an idle cycle leaves the word still. Only the bench's scenarios can show that the carry, half-carry and overflow values are right for specific operand pairs, such as 0x7F incremented and 0x88 minus 0x0A. The same holds for the carry chain feeding add-with-carry, the ordering when an operation and a command collide, and the reset value.

// File: rtl/alu_status_pkg.sv
// Package: shared operation codes and status-word bit positions.
// Assumes an 8-bit status word; bit positions are fixed because
// downstream branch logic decodes them.
package alu_status_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4,
        OP_LSL  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    localparam int SR_W   = 8;
    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_S = 4;
    localparam int FLAG_H = 5;
    localparam int FLAG_T = 6;
    localparam int FLAG_I = 7;

    // Flags produced by the adder/shifter before result-based flags are added.
    typedef struct packed {
        logic h;
        logic v;
        logic c;
    } arith_flags_t;

endpackage

// File: rtl/alu_arith_core.sv
// Module: arithmetic core. Produces the result plus carry, half-carry and
// overflow for the selected operation. Purely combinational.
// Assumes DATA_W is even and at least 4 so the nibble boundary exists.
// Carry passes through unchanged for increment and decrement.
module alu_arith_core
    import alu_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output arith_flags_t      fl,
    output logic              op_known
);
    localparam int NIB = DATA_W / 2;
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W:0] wide;
    logic [NIB:0]    low;
    logic            cin;

    // Operation select: result and arithmetic flags.
    always_comb begin
        wide     = '0;
        low      = '0;
        cin      = 1'b0;
        result   = '0;
        fl       = '{h: 1'b0, v: 1'b0, c: carry_in};
        op_known = 1'b1;
        case (alu_op_e'(op))
            OP_ADD, OP_ADC: begin
                cin    = (alu_op_e'(op) == OP_ADC) ? carry_in : 1'b0;
                wide   = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
                low    = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
                result = wide[DATA_W-1:0];
                fl.c   = wide[DATA_W];
                fl.h   = low[NIB];
                fl.v   = (a[MSB] == b[MSB]) && (result[MSB] != a[MSB]);
            end
            OP_SUB: begin
                wide   = {1'b0, a} - {1'b0, b};
                low    = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]};
                result = wide[DATA_W-1:0];
                fl.c   = wide[DATA_W];
                fl.h   = low[NIB];
                fl.v   = (a[MSB] != b[MSB]) && (result[MSB] != a[MSB]);
            end
            OP_INC: begin
                result = a + ONE;
                fl.h   = &a[NIB-1:0];
                fl.v   = (a == MAX_POS);
            end
            OP_DEC: begin
                result = a - ONE;
                fl.h   = ~|a[NIB-1:0];
                fl.v   = (a == MIN_NEG);
            end
            OP_LSL: begin
                result = {a[MSB-1:0], 1'b0};
                fl.c   = a[MSB];
                fl.h   = a[NIB-1];
                fl.v   = a[MSB] ^ a[MSB-1];
            end
            default: op_known = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_result_flags.sv
// Module: result-derived flags. Zero, negative and sign follow from the
// finished result and the overflow bit. Combinational.
module alu_result_flags #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] result,
    input  logic              v_in,
    output logic              z,
    output logic              n,
    output logic              s
);
    // Zero detect, sign bit, and sign corrected for overflow.
    always_comb begin
        z = (result == '0);
        n = result[DATA_W-1];
        s = n ^ v_in;
    end

endmodule

// File: rtl/alu_status_reg.sv
// Module: status word storage. Priority from highest: reset, full write,
// then operation flags with a single-bit command layered on top.
// Assumes upd_bits is ordered H,S,V,N,Z,C matching bits 5..0.
module alu_status_reg
    import alu_status_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SR_W-1:0] wr_data,
    input  logic            upd_en,
    input  logic [5:0]      upd_bits,
    input  logic            cmd_en,
    input  logic            cmd_set,
    input  logic [2:0]      cmd_sel,
    output logic [SR_W-1:0] q
);
    logic [SR_W-1:0] nxt;

    // Merge operation flags, then the single-bit command.
    always_comb begin
        nxt = q;
        if (upd_en) begin
            nxt[FLAG_H:FLAG_C] = upd_bits;
        end
        if (cmd_en) begin
            nxt[cmd_sel] = cmd_set;
        end
    end

    // Register with synchronous active-low reset and write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/alu_status_unit.sv
// Module: top level. Connects the arithmetic core, result-flag logic and
// status register. The result is combinational; flags latch on the edge
// after a strobe. Add-with-carry reads the stored carry bit.
module alu_status_unit
    import alu_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    input  logic              flag_cmd_valid,
    input  logic              flag_cmd_set,
    input  logic [2:0]        flag_cmd_sel,
    input  logic              wr_en,
    input  logic [SR_W-1:0]   wr_data,
    output logic [SR_W-1:0]   status
);
    arith_flags_t afl;
    logic         op_known;
    logic         z_flag;
    logic         n_flag;
    logic         s_flag;
    logic [5:0]   upd_bits;
    logic         upd_en;

    alu_arith_core #(.DATA_W(DATA_W)) u_core (
        .op       (op_code),
        .a        (opnd_a),
        .b        (opnd_b),
        .carry_in (status[FLAG_C]),
        .result   (result),
        .fl       (afl),
        .op_known (op_known)
    );

    alu_result_flags #(.DATA_W(DATA_W)) u_rflags (
        .result (result),
        .v_in   (afl.v),
        .z      (z_flag),
        .n      (n_flag),
        .s      (s_flag)
    );

    // Pack flags in register order and qualify the update.
    always_comb begin
        upd_bits = {afl.h, s_flag, afl.v, n_flag, z_flag, afl.c};
        upd_en   = op_valid && op_known;
    end

    alu_status_reg u_sreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .upd_en   (upd_en),
        .upd_bits (upd_bits),
        .cmd_en   (flag_cmd_valid),
        .cmd_set  (flag_cmd_set),
        .cmd_sel  (flag_cmd_sel),
        .q        (status)
    );

endmodule

// File: rtl/alu_status_checker.sv
// Module: property checker for alu_status_unit, attached through bind.
// Observes ports only.
module alu_status_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [DATA_W-1:0] result,
    input logic              flag_cmd_valid,
    input logic              flag_cmd_set,
    input logic [2:0]        flag_cmd_sel,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [7:0]        status
);
    logic lone_op;
    logic lone_cmd;

    always_comb begin
        lone_op  = op_valid && (op_code <= 3'd5) && !wr_en && !flag_cmd_valid;
        lone_cmd = flag_cmd_valid && !op_valid && !wr_en;
    end

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status == $past(wr_data));

    a_r8_ti_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en && !flag_cmd_valid) |=> status[7:6] == $past(status[7:6]));

    a_r6_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        lone_op |=> status[4] == (status[2] ^ status[3]));

    a_r4_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        lone_op |=> status[1] == ($past(result) == '0));

    a_r4_neg_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        lone_op |=> status[2] == $past(result[DATA_W-1]));

    a_r9_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        lone_cmd |=> $countones(status ^ $past(status)) <= 1);

    a_r9_bit_value: assert property (@(posedge clk) disable iff (!rst_n)
        lone_cmd |=> status[$past(flag_cmd_sel)] == $past(flag_cmd_set));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !wr_en && !flag_cmd_valid) |=> $stable(status));

endmodule

bind alu_status_unit alu_status_checker #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .op_code        (op_code),
    .result         (result),
    .flag_cmd_valid (flag_cmd_valid),
    .flag_cmd_set   (flag_cmd_set),
    .flag_cmd_sel   (flag_cmd_sel),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .status         (status)
);

// File: tb/alu_status_unit_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module alu_status_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [7:0] result;
    logic       flag_cmd_valid = 1'b0;
    logic       flag_cmd_set = 1'b0;
    logic [2:0] flag_cmd_sel = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] status;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_status_unit u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_valid       (op_valid),
        .op_code        (op_code),
        .opnd_a         (opnd_a),
        .opnd_b         (opnd_b),
        .result         (result),
        .flag_cmd_valid (flag_cmd_valid),
        .flag_cmd_set   (flag_cmd_set),
        .flag_cmd_sel   (flag_cmd_sel),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .status         (status)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // Drive every input for one cycle at the falling edge, check result, clock, check status.
    task automatic step(input logic ov, input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic cv, input logic cs, input logic [2:0] csel,
                        input logic we, input logic [7:0] wd,
                        input logic chk_res, input logic [7:0] exp_res,
                        input logic [7:0] exp_sr, input string tag);
        @(negedge clk);
        op_valid = ov; op_code = op; opnd_a = a; opnd_b = b;
        flag_cmd_valid = cv; flag_cmd_set = cs; flag_cmd_sel = csel;
        wr_en = we; wr_data = wd;
        #1;
        if (chk_res) check8({tag, " result"}, result, exp_res);
        @(posedge clk);
        #1;
        op_valid = 1'b0; flag_cmd_valid = 1'b0; wr_en = 1'b0;
        check8({tag, " status"}, status, exp_sr);
    endtask

    task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] er, input logic [7:0] es, input string tag);
        step(1'b1, op, a, b, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, er, es, tag);
    endtask

    task automatic do_cmd(input logic s, input logic [2:0] sel, input logic [7:0] es, input string tag);
        step(1'b0, 3'd0, 8'h00, 8'h00, 1'b1, s, sel, 1'b0, 8'h00, 1'b0, 8'h00, es, tag);
    endtask

    task automatic do_wr(input logic [7:0] v);
        step(1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, v, 1'b0, 8'h00, v, "R10 write");
    endtask

    task automatic t_reset_state();
        repeat (2) @(posedge clk);
        #1;
        check8("R1 reset value", status, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        do_op(3'd0, 8'hFF, 8'hFF, 8'hFE, 8'h35, "R3 R7 add FF+FF");
        do_op(3'd0, 8'h01, 8'h02, 8'h03, 8'h00, "R3 add 01+02 no carry");
    endtask

    task automatic t_adc();
        do_op(3'd0, 8'hFF, 8'h01, 8'h00, 8'h23, "R4 add to zero");
        do_op(3'd1, 8'h10, 8'h20, 8'h31, 8'h00, "R2 adc carry in 1");
        do_op(3'd1, 8'h10, 8'h20, 8'h30, 8'h00, "R2 adc carry in 0");
    endtask

    task automatic t_sub();
        do_op(3'd2, 8'h88, 8'h0A, 8'h7E, 8'h38, "R6 sub 88-0A sign");
        do_op(3'd2, 8'h05, 8'h07, 8'hFE, 8'h35, "R3 sub borrow");
        do_op(3'd2, 8'h07, 8'h07, 8'h00, 8'h02, "R4 sub to zero");
    endtask

    task automatic t_signed_add();
        do_op(3'd0, 8'h78, 8'h0A, 8'h82, 8'h2C, "R5 R6 add 78+0A overflow");
    endtask

    task automatic t_inc_dec();
        do_wr(8'h01);
        do_op(3'd3, 8'h7F, 8'h00, 8'h80, 8'h2D, "R5 inc 7F keeps C");
        do_wr(8'h00);
        do_op(3'd3, 8'h0F, 8'h00, 8'h10, 8'h20, "R7 inc 0F half carry");
        do_op(3'd4, 8'h80, 8'h00, 8'h7F, 8'h38, "R5 dec 80 overflow");
        do_wr(8'h01);
        do_op(3'd4, 8'h01, 8'h00, 8'h00, 8'h03, "R3 R4 dec to zero keeps C");
    endtask

    task automatic t_lsl();
        do_op(3'd5, 8'h80, 8'h55, 8'h00, 8'h1B, "R3 lsl msb into C");
        do_op(3'd5, 8'h00, 8'h55, 8'h00, 8'h02, "R3 lsl zero");
        do_op(3'd5, 8'h48, 8'h00, 8'h90, 8'h2C, "R7 lsl bit3 and overflow");
    endtask

    task automatic t_t_and_i();
        do_wr(8'h00);
        do_cmd(1'b1, 3'd6, 8'h40, "R9 set T");
        do_cmd(1'b1, 3'd7, 8'hC0, "R9 set I");
        do_op(3'd0, 8'hFF, 8'hFF, 8'hFE, 8'hF5, "R8 add keeps T I");
        do_op(3'd2, 8'h05, 8'h07, 8'hFE, 8'hF5, "R8 sub keeps T I");
        do_cmd(1'b0, 3'd7, 8'h75, "R9 clear I");
    endtask

    task automatic t_all_cmds();
        logic [7:0] exp;
        do_wr(8'h00);
        exp = 8'h00;
        for (int i = 0; i < 8; i++) begin
            exp[i] = 1'b1;
            do_cmd(1'b1, 3'(i), exp, $sformatf("R9 set bit %0d", i));
        end
        for (int i = 0; i < 8; i++) begin
            exp[i] = 1'b0;
            do_cmd(1'b0, 3'(i), exp, $sformatf("R9 clear bit %0d", i));
        end
    endtask

    task automatic t_write_priority();
        do_wr(8'h00);
        step(1'b1, 3'd0, 8'hFF, 8'hFF, 1'b1, 1'b1, 3'd1, 1'b1, 8'hA5, 1'b1, 8'hFE, 8'hA5, "R10 write beats op and cmd");
    endtask

    task automatic t_op_with_cmd();
        do_wr(8'h00);
        step(1'b1, 3'd0, 8'h01, 8'h02, 1'b1, 1'b1, 3'd1, 1'b0, 8'h00, 1'b1, 8'h03, 8'h02, "R11 cmd sets Z over op");
        step(1'b1, 3'd0, 8'hFF, 8'hFF, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 8'hFE, 8'h34, "R11 cmd clears C over op");
    endtask

    task automatic t_reserved();
        do_wr(8'h5A);
        do_op(3'd6, 8'hFF, 8'hFF, 8'h00, 8'h5A, "R8 code 6 no change");
        do_op(3'd7, 8'h80, 8'h80, 8'h00, 8'h5A, "R8 code 7 no change");
    endtask

    task automatic t_idle();
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 3'd0, 8'hFF, 8'h01, 1'b0, 1'b1, 3'd2, 1'b0, 8'h00, 1'b0, 8'h00, 8'h5A, "R11 no strobe holds");
        end
    endtask

    task automatic t_reset_again();
        do_wr(8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check8("R1 reset clears word", status, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_add();
        t_adc();
        t_sub();
        t_signed_add();
        t_inc_dec();
        t_lsl();
        t_t_and_i();
        t_all_cmds();
        t_write_priority();
        t_op_with_cmd();
        t_reserved();
        t_idle();
        t_reset_again();
        summary();
        $finish;
    end

endmodule